// File: doc/BRIEF.md
# Sliding-Window Rank-Order Filter

This block takes an unbroken stream of unsigned 16-bit samples and keeps the 32 most recent ones in a register array. The array is always held in ascending order. Each accepted sample replaces the oldest sample in the window, and the block reports one order statistic: the 24th smallest value. This is a non-median rank. It suits uses such as upper-percentile envelope tracking, where a single large outlier must not move the output.

Each update finishes in one clock, so a new sample can arrive on every cycle. The new sample is compared in parallel with every stored entry except the one that is leaving. Every slot then picks its next content from a small local multiplexer. Every entry carries an age tag, and this tag marks which entry leaves next. After reset the array is empty. Empty slots act as larger than any value, so the first samples settle into correct sorted order while the window fills.

Top module: `rank_window_filter`

## Requirements
- R1: A synchronous reset empties the window and clears the sample count. After the reset edge, `out_valid` is 0 and `out_rank` is 0.
- R2: `out_valid` stays 0 until 32 samples have been accepted since the last reset. It is 1 from then on.
- R3: While `out_valid` is 1, `out_rank` equals the value at zero-based index 23 of the 32 most recent accepted samples sorted in ascending unsigned order.
- R4: The result that includes a sample accepted at a clock edge appears on `out_rank` right after that same edge. This is one registered stage of latency.
- R5: On a cycle with `in_valid` low, the window does not change and `out_rank` and `out_valid` keep their values, whatever `in_sample` carries.
- R6: Back-to-back accepted samples each push the oldest sample out, so the window slides by exactly one sample per accepted sample.
- R7: Repeated values and the extreme codes 0x0000 and 0xFFFF are ranked correctly. A new sample equal to stored entries is placed after them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Accept `in_sample` on this edge |
| in_sample | input | 16 | Unsigned input sample |
| out_valid | output | 1 | Window full, `out_rank` meaningful |
| out_rank | output | 16 | 24th smallest value of the current window |

## Verification
The assertions assume that reset is held for at least one edge before the first sample. They also assume that `in_valid` is a clean level sampled at the rising edge, so that any edge where it is low is a true hold cycle. The bench drives every input on the falling edge and raises reset from time zero, so both conditions hold. Its stimulus includes runs with `in_valid` low while `in_sample` keeps changing, long runs of equal values, and alternating extreme codes. These runs exercise the hold property and the tie-ordering rule that keeps the array sorted and the age tags a permutation.

// File: rtl/rank_window_filter.sv
module rank_window_filter #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int RANK  = 24
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  output logic          out_valid,
  output logic [DW-1:0] out_rank
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] OLDEST = AW'(DEPTH - 1);

  logic [DEPTH-1:0][DW-1:0] val_q, val_d, rv;
  logic [DEPTH-1:0][AW-1:0] age_q, age_d, ra;
  logic [DEPTH-1:0]         occ_q, occ_d, ro, le;
  logic [CW-1:0]            cnt_q;
  logic [DW-1:0]            rank_q;
  logic [AW-1:0]            del_idx;
  logic                     full;

  assign full      = (cnt_q == CW'(DEPTH));
  assign out_valid = full;
  assign out_rank  = rank_q;

  always_comb begin
    del_idx = OLDEST;
    if (full)
      for (int i = 0; i < DEPTH; i++)
        if (age_q[i] == OLDEST) del_idx = AW'(i);
  end

  for (genvar j = 0; j < DEPTH; j++) begin : g_slot
    if (j < DEPTH - 1) begin : g_rem
      assign rv[j] = (AW'(j) < del_idx) ? val_q[j] : val_q[j+1];
      assign ra[j] = (AW'(j) < del_idx) ? age_q[j] : age_q[j+1];
      assign ro[j] = (AW'(j) < del_idx) ? occ_q[j] : occ_q[j+1];
    end else begin : g_top
      assign rv[j] = '0;
      assign ra[j] = '0;
      assign ro[j] = 1'b0;
    end

    assign le[j] = ro[j] && (rv[j] <= in_sample);

    if (j == 0) begin : g_first
      assign val_d[j] = le[j] ? rv[j]          : in_sample;
      assign age_d[j] = le[j] ? ra[j] + 1'b1   : '0;
      assign occ_d[j] = le[j] ? ro[j]          : 1'b1;
    end else begin : g_rest
      assign val_d[j] = le[j] ? rv[j]        : (le[j-1] ? in_sample : rv[j-1]);
      assign age_d[j] = le[j] ? ra[j] + 1'b1 : (le[j-1] ? '0 : ra[j-1] + 1'b1);
      assign occ_d[j] = le[j] ? ro[j]        : (le[j-1] ? 1'b1 : ro[j-1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q  <= '0;
      cnt_q  <= '0;
      rank_q <= '0;
    end else if (in_valid) begin
      val_q  <= val_d;
      age_q  <= age_d;
      occ_q  <= occ_d;
      rank_q <= val_d[RANK-1];
      if (!full) cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/rank_window_filter_chk.sv
module rank_window_filter_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 32,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_valid,
  input logic                     out_valid,
  input logic [DW-1:0]            out_rank,
  input logic [CW-1:0]            cnt,
  input logic [DEPTH-1:0]         occ,
  input logic [DEPTH-1:0][DW-1:0] val,
  input logic [DEPTH-1:0][AW-1:0] age
);
  logic [DEPTH-1:0] oldest;
  for (genvar i = 0; i < DEPTH; i++) begin : g_old
    assign oldest[i] = occ[i] && (age[i] == AW'(DEPTH - 1));
  end

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(in_valid) && !$past(rst)) |-> ($stable(out_rank) && $stable(out_valid)));

  assert_full_window_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (&occ));

  assert_fill_count_R2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(in_valid) && !$past(out_valid)) |-> (cnt == $past(cnt) + 1'b1));

  assert_single_oldest_R6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(oldest) == 1));

  for (genvar j = 0; j < DEPTH - 1; j++) begin : g_ord
    assert_sorted_R3: assert property (@(posedge clk) disable iff (rst)
      occ[j+1] |-> (occ[j] && (val[j] <= val[j+1])));
  end
endmodule

bind rank_window_filter rank_window_filter_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
  .out_rank(out_rank), .cnt(cnt_q), .occ(occ_q), .val(val_q), .age(age_q)
);

// File: tb/rank_window_filter_test.sv
module rank_window_filter_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 40;
  localparam logic [15:0] STIM [0:N-1] = '{
    16'h1234, 16'h0001, 16'hFFFE, 16'h8000, 16'h7FFF, 16'h0400, 16'h0400, 16'hA5A5,
    16'h5A5A, 16'h0000, 16'hFFFF, 16'h3333, 16'hCCCC, 16'h0010, 16'h1000, 16'h2468,
    16'h9999, 16'h0400, 16'hBEEF, 16'h0BAD, 16'hF00D, 16'h7777, 16'h7778, 16'h7776,
    16'h4000, 16'hC000, 16'h0042, 16'hE000, 16'h6000, 16'h2000, 16'hD00D, 16'h1111,
    16'hFACE, 16'h0007, 16'h8001, 16'h3FFF, 16'hABCD, 16'h0400, 16'h9000, 16'h00FF};

  logic clk = 0, rst = 1, in_valid = 0;
  logic [15:0] in_sample = '0;
  logic out_valid;
  logic [15:0] out_rank;
  int checks = 0, fails = 0;
  logic [15:0] hist [0:31];
  int mcount = 0, wp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rank_window_filter uut (.clk(clk), .rst(rst), .in_valid(in_valid),
    .in_sample(in_sample), .out_valid(out_valid), .out_rank(out_rank));

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model_rank();
    logic [15:0] t [0:31];
    for (int i = 0; i < 32; i++) t[i] = hist[i];
    for (int i = 1; i < 32; i++)
      for (int k = i; k > 0 && t[k-1] > t[k]; k--) begin
        logic [15:0] s = t[k]; t[k] = t[k-1]; t[k-1] = s;
      end
    return t[23];
  endfunction

  task automatic step(input logic v, input logic [15:0] x);
    logic [15:0] prev_rank = out_rank;
    logic prev_valid = out_valid;
    in_valid = v; in_sample = x;
    @(posedge clk);
    if (v) begin hist[wp] = x; wp = (wp + 1) % 32; mcount++; end
    @(negedge clk);
    in_valid = 0;
    if (!v) begin
      check("R5 rank hold", out_rank, prev_rank);
      check("R5 valid hold", 16'(out_valid), 16'(prev_valid));
    end else begin
      check("R2 valid", 16'(out_valid), 16'(mcount >= 32));
      if (mcount >= 32) check("R3,R4 rank", out_rank, model_rank());
    end
  endtask

  task automatic do_reset();
    rst = 1;
    @(posedge clk);
    @(negedge clk);
    check("R1 valid", 16'(out_valid), 16'h0);
    check("R1 rank", out_rank, 16'h0);
    rst = 0; mcount = 0; wp = 0;
    for (int i = 0; i < 32; i++) hist[i] = '0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    for (int i = 0; i < N; i++) step(1'b1, STIM[i]);
    for (int i = 0; i < 4; i++) step(1'b0, 16'hDEAD + 16'(i));
    for (int i = 0; i < 24; i++) begin
      step(1'b1, STIM[(i * 7) % N] ^ 16'h0F0F);
      step(1'b0, 16'h0000);
    end

    do_reset();
    for (int i = 0; i < 31; i++) step(1'b1, 16'(i * 3));
    check("R2 not full after 31", 16'(out_valid), 16'h0);
    step(1'b1, 16'd500);
    check("R4 first result", out_rank, 16'd69);
    do_reset();
    for (int i = 0; i < 64; i++) step(1'b1, 16'(i));
    check("R6 ascending slide", out_rank, 16'd55);
    for (int i = 0; i < 40; i++) step(1'b1, 16'(1000 - i));
    check("R6 descending slide", out_rank, 16'(1000 - 39 + 23));

    for (int i = 0; i < 32; i++) step(1'b1, 16'h7777);
    check("R7 all equal", out_rank, 16'h7777);
    for (int i = 0; i < 32; i++) step(1'b1, (i % 2) ? 16'hFFFF : 16'h0000);
    check("R7 extremes", out_rank, 16'hFFFF);
    for (int i = 0; i < 24; i++) step(1'b1, 16'h0000);
    check("R7 low ties", out_rank, 16'h0000);
    step(1'b1, 16'h0000);
    check("R7 tie shift", out_rank, 16'h0000);

    do_reset();
    check("R1 after run", out_rank, 16'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule